// File: doc/BRIEF.md
# Data-Side Micro Translation Cache

This block is a four-slot translation cache placed in front of a larger paired-entry main TLB, serving data accesses only. A virtual address presented on the lookup port is compared against all four slots at once. On a match, the physical address and cache attribute come back in the same cycle. Every slot covers one fixed 4KB page. The block has no software-visible state: slots are filled from the main TLB and discarded whenever that TLB is written or the current address space identifier changes.

On a lookup miss the block raises `stall` and holds off the requester. It then sends the virtual page number and address space identifier to the main TLB over a valid/ready request port and waits for the single-cycle response. A successful response is installed in the slot chosen by a three-bit tree pseudo-LRU. The lookup then finishes as a hit on the next cycle. If the main TLB has no mapping either, nothing is installed and the requester receives a result flagged as a miss.

Back-pressure rules are as follows. The requester holds `req_valid` and `req_vaddr` steady until it sees `req_ready`. `req_ready` is high only in the cycle that delivers the result, and the result carries no ready of its own because the consumer always takes it. The main-TLB request port follows valid/ready with the same holding rule. The main-TLB response is a one-cycle valid pulse with no back-pressure.

Top module: `utlb_dside`

## Requirements
- R1: When the presented page and the current identifier match a valid slot, `rsp_valid` and `req_ready` are high in that same cycle, `rsp_paddr` equals the stored frame number followed by the 12-bit page offset, `rsp_attr` is the stored attribute, `rsp_miss` is low, `stall` is low, and no main-TLB request follows.
- R2: On a lookup miss `stall` is high in the cycle of the miss. Exactly one main-TLB request is then issued with the page number and identifier. It stays valid and unchanged until `mt_req_ready` accepts it, and `req_ready` stays low meanwhile.
- R3: After a main-TLB response with `mt_rsp_hit` high, the waiting lookup completes in the following cycle as a hit carrying the returned frame and attribute. No further request is made.
- R4: The victim is chosen by a tree: a top bit names the less recently used pair (slots 0,1 or slots 2,3), and a per-pair bit names the less recently used slot inside that pair. From reset the bits are all zero, so successive fills with no intervening hits land in slots 0, 2, 1, 3.
- R5: Every accepted hit and every fill marks its slot as most recently used: the top bit points to the other pair, and that pair's bit points to the other slot.
- R6: When the main-TLB response has `mt_rsp_hit` low, no slot is written. The lookup completes in that cycle with `rsp_miss` high, `rsp_paddr` and `rsp_attr` zero. A repeat of the same lookup issues a new request.
- R7: A change of `cur_asid` invalidates all four slots.
- R8: A one-cycle pulse on `main_tlb_wr` invalidates all four slots.
- R9: If an invalidation occurs while a refill is outstanding, that response is discarded. The lookup re-misses and fetches again, so it completes only after a second request.
- R10: After reset all slots are invalid, `stall`, `mt_req_valid` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_asid | input | ASID_W | Current address space identifier |
| main_tlb_wr | input | 1 | Pulse when the main TLB is written; flushes all slots |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup accepted and result delivered this cycle |
| req_vaddr | input | VADDR_W | Virtual address to translate |
| rsp_valid | output | 1 | Result valid (equals accepted lookup) |
| rsp_paddr | output | PFN_W+PAGE_W | Physical address |
| rsp_attr | output | ATTR_W | Cache attribute of the page |
| rsp_miss | output | 1 | No mapping exists in the main TLB |
| stall | output | 1 | Lookup blocked on a refill |
| mt_req_valid | output | 1 | Refill request valid |
| mt_req_ready | input | 1 | Main TLB accepts the refill request |
| mt_req_vpn | output | VADDR_W-PAGE_W | Page number to refill |
| mt_req_asid | output | ASID_W | Identifier of the refill |
| mt_rsp_valid | input | 1 | One-cycle refill response |
| mt_rsp_hit | input | 1 | Main TLB found a mapping |
| mt_rsp_pfn | input | PFN_W | Returned physical frame number |
| mt_rsp_attr | input | ATTR_W | Returned cache attribute |

## Verification
The bench builds the block with its default parameters: 32-bit virtual addresses, 12-bit page offset, 8-bit identifier, 24-bit frame and 3-bit attribute. With those widths, a page number whose top nibble is all ones is unmapped in the bench's main-TLB model, which brings the refill-miss path within reach. The model also folds the identifier into the returned frame, so a refill after an identifier change shows a different physical address. The model delays acceptance by two cycles and answers two cycles after acceptance, which leaves room to pulse an invalidation during the request phase and check the discard-and-refetch path.

// File: rtl/utlb_pkg.sv
package utlb_pkg;
  localparam int unsigned UTLB_SLOTS = 4;
  localparam int unsigned UTLB_IDX_W = 2;

  typedef enum logic [1:0] {
    FS_LOOKUP = 2'd0,
    FS_ASK    = 2'd1,
    FS_WAIT   = 2'd2
  } fill_state_e;
endpackage

// File: rtl/utlb_entry_array.sv
module utlb_entry_array
  import utlb_pkg::*;
#(
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned ASID_W = 8,
  parameter int unsigned PFN_W  = 24,
  parameter int unsigned ATTR_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic [VPN_W-1:0]      lk_vpn,
  input  logic [ASID_W-1:0]     lk_asid,
  input  logic                  wr_en,
  input  logic [UTLB_IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0]      wr_vpn,
  input  logic [ASID_W-1:0]     wr_asid,
  input  logic [PFN_W-1:0]      wr_pfn,
  input  logic [ATTR_W-1:0]     wr_attr,
  output logic                  hit,
  output logic [UTLB_IDX_W-1:0] hit_idx,
  output logic [PFN_W-1:0]      hit_pfn,
  output logic [ATTR_W-1:0]     hit_attr
);
  logic [UTLB_SLOTS-1:0] valid_vec;
  logic [UTLB_SLOTS-1:0] match_vec;
  logic [PFN_W-1:0]      pfn_arr  [UTLB_SLOTS];
  logic [ATTR_W-1:0]     attr_arr [UTLB_SLOTS];

  for (genvar g = 0; g < UTLB_SLOTS; g++) begin : g_slot
    logic              valid_q;
    logic [VPN_W-1:0]  vpn_q;
    logic [ASID_W-1:0] asid_q;
    logic [PFN_W-1:0]  pfn_q;
    logic [ATTR_W-1:0] attr_q;
    logic              sel;

    assign sel = wr_en && (wr_idx == UTLB_IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q <= 1'b0;
        vpn_q   <= '0;
        asid_q  <= '0;
        pfn_q   <= '0;
        attr_q  <= '0;
      end else if (flush) begin
        valid_q <= 1'b0;
      end else if (sel) begin
        valid_q <= 1'b1;
        vpn_q   <= wr_vpn;
        asid_q  <= wr_asid;
        pfn_q   <= wr_pfn;
        attr_q  <= wr_attr;
      end
    end

    assign match_vec[g] = valid_q && (vpn_q == lk_vpn) && (asid_q == lk_asid);
    assign valid_vec[g] = valid_q;
    assign pfn_arr[g]   = pfn_q;
    assign attr_arr[g]  = attr_q;
  end

  always_comb begin
    hit_idx  = '0;
    hit_pfn  = '0;
    hit_attr = '0;
    for (int i = 0; i < UTLB_SLOTS; i++) begin
      if (match_vec[i]) begin
        hit_idx  = hit_idx | UTLB_IDX_W'(i);
        hit_pfn  = hit_pfn | pfn_arr[i];
        hit_attr = hit_attr | attr_arr[i];
      end
    end
  end

  assign hit = |match_vec;

  // R1: a page never sits in two slots, so the OR-mux is exact
  p_single_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec))
    else $error("two slots match one lookup");

  // R7 / R8: an invalidation empties every slot, winning over a same-cycle fill
  p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_vec == '0))
    else $error("slot survived invalidation");
endmodule

// File: rtl/utlb_plru.sv
module utlb_plru
  import utlb_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  touch_en,
  input  logic [UTLB_IDX_W-1:0] touch_idx,
  output logic [UTLB_IDX_W-1:0] victim_idx
);
  logic       older_pair_q;
  logic [1:0] older_in_pair_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      older_pair_q    <= 1'b0;
      older_in_pair_q <= 2'b00;
    end else if (touch_en) begin
      older_pair_q                   <= ~touch_idx[1];
      older_in_pair_q[touch_idx[1]]  <= ~touch_idx[0];
    end
  end

  assign victim_idx = {older_pair_q, older_in_pair_q[older_pair_q]};

  // R5: after a use, the next victim lies in the other pair
  p_use_moves_victim_r5: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> (victim_idx[1] != $past(touch_idx[1])))
    else $error("victim still in the pair just used");
endmodule

// File: rtl/utlb_refill_ctl.sv
module utlb_refill_ctl
  import utlb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic hit,
  input  logic flush,
  input  logic mt_req_ready,
  input  logic mt_rsp_valid,
  input  logic mt_rsp_hit,
  output logic in_lookup,
  output logic start_miss,
  output logic mt_req_valid,
  output logic fill_en,
  output logic fail_now,
  output logic stall,
  output logic req_ready
);
  fill_state_e state_q, state_d;
  logic        stale_q;
  logic        rsp_now;
  logic        drop;

  assign in_lookup    = (state_q == FS_LOOKUP);
  assign start_miss   = in_lookup && req_valid && !hit;
  assign mt_req_valid = (state_q == FS_ASK);
  assign rsp_now      = (state_q == FS_WAIT) && mt_rsp_valid;
  assign drop         = rsp_now && (stale_q || flush);
  assign fill_en      = rsp_now && !drop && mt_rsp_hit;
  assign fail_now     = rsp_now && !drop && !mt_rsp_hit;
  assign req_ready    = (in_lookup && hit) || fail_now;
  assign stall        = start_miss || (!in_lookup && !fail_now);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      FS_LOOKUP: if (start_miss)   state_d = FS_ASK;
      FS_ASK:    if (mt_req_ready) state_d = FS_WAIT;
      FS_WAIT:   if (mt_rsp_valid) state_d = FS_LOOKUP;
      default:                     state_d = FS_LOOKUP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= FS_LOOKUP;
      stale_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_miss)
        stale_q <= 1'b0;
      else if (!in_lookup && flush)
        stale_q <= 1'b1;
    end
  end

  // R2: a refill request is held until the main TLB takes it
  p_ask_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mt_req_valid && !mt_req_ready) |=> mt_req_valid)
    else $error("refill request withdrawn before acceptance");

  // R9: a response that follows an invalidation is never installed
  p_stale_not_filled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == FS_WAIT) && $past(flush) && !in_lookup) |-> !fill_en)
    else $error("stale refill installed");
endmodule

// File: rtl/utlb_dside.sv
module utlb_dside
  import utlb_pkg::*;
#(
  parameter int unsigned VADDR_W = 32,
  parameter int unsigned PAGE_W  = 12,
  parameter int unsigned ASID_W  = 8,
  parameter int unsigned PFN_W   = 24,
  parameter int unsigned ATTR_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ASID_W-1:0]         cur_asid,
  input  logic                      main_tlb_wr,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [VADDR_W-1:0]        req_vaddr,
  output logic                      rsp_valid,
  output logic [PFN_W+PAGE_W-1:0]   rsp_paddr,
  output logic [ATTR_W-1:0]         rsp_attr,
  output logic                      rsp_miss,
  output logic                      stall,
  output logic                      mt_req_valid,
  input  logic                      mt_req_ready,
  output logic [VADDR_W-PAGE_W-1:0] mt_req_vpn,
  output logic [ASID_W-1:0]         mt_req_asid,
  input  logic                      mt_rsp_valid,
  input  logic                      mt_rsp_hit,
  input  logic [PFN_W-1:0]          mt_rsp_pfn,
  input  logic [ATTR_W-1:0]         mt_rsp_attr
);
  localparam int unsigned VPN_W   = VADDR_W - PAGE_W;
  localparam int unsigned PADDR_W = PFN_W + PAGE_W;

  logic [VPN_W-1:0]      lk_vpn;
  logic [ASID_W-1:0]     asid_seen_q;
  logic                  flush;
  logic [VPN_W-1:0]      pend_vpn_q;
  logic [ASID_W-1:0]     pend_asid_q;
  logic                  hit;
  logic [UTLB_IDX_W-1:0] hit_idx;
  logic [PFN_W-1:0]      hit_pfn;
  logic [ATTR_W-1:0]     hit_attr;
  logic [UTLB_IDX_W-1:0] victim_idx;
  logic                  in_lookup;
  logic                  start_miss;
  logic                  fill_en;
  logic                  fail_now;
  logic                  touch_en;
  logic [UTLB_IDX_W-1:0] touch_idx;

  assign lk_vpn = req_vaddr[VADDR_W-1:PAGE_W];
  assign flush  = main_tlb_wr || (cur_asid != asid_seen_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      asid_seen_q <= '0;
      pend_vpn_q  <= '0;
      pend_asid_q <= '0;
    end else begin
      asid_seen_q <= cur_asid;
      if (start_miss) begin
        pend_vpn_q  <= lk_vpn;
        pend_asid_q <= cur_asid;
      end
    end
  end

  utlb_entry_array #(
    .VPN_W (VPN_W),
    .ASID_W(ASID_W),
    .PFN_W (PFN_W),
    .ATTR_W(ATTR_W)
  ) u_slots (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .lk_vpn  (lk_vpn),
    .lk_asid (cur_asid),
    .wr_en   (fill_en),
    .wr_idx  (victim_idx),
    .wr_vpn  (pend_vpn_q),
    .wr_asid (pend_asid_q),
    .wr_pfn  (mt_rsp_pfn),
    .wr_attr (mt_rsp_attr),
    .hit     (hit),
    .hit_idx (hit_idx),
    .hit_pfn (hit_pfn),
    .hit_attr(hit_attr)
  );

  assign touch_en  = (in_lookup && req_valid && hit) || fill_en;
  assign touch_idx = fill_en ? victim_idx : hit_idx;

  utlb_plru u_repl (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (touch_en),
    .touch_idx (touch_idx),
    .victim_idx(victim_idx)
  );

  utlb_refill_ctl u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .hit         (hit),
    .flush       (flush),
    .mt_req_ready(mt_req_ready),
    .mt_rsp_valid(mt_rsp_valid),
    .mt_rsp_hit  (mt_rsp_hit),
    .in_lookup   (in_lookup),
    .start_miss  (start_miss),
    .mt_req_valid(mt_req_valid),
    .fill_en     (fill_en),
    .fail_now    (fail_now),
    .stall       (stall),
    .req_ready   (req_ready)
  );

  assign mt_req_vpn  = pend_vpn_q;
  assign mt_req_asid = pend_asid_q;
  assign rsp_valid   = req_valid && req_ready;
  assign rsp_miss    = fail_now;
  assign rsp_paddr   = fail_now ? PADDR_W'(0) : {hit_pfn, req_vaddr[PAGE_W-1:0]};
  assign rsp_attr    = fail_now ? ATTR_W'(0) : hit_attr;

  // R1: a delivered hit never leads to a refill request
  p_hit_no_ask_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_miss) |=> !mt_req_valid)
    else $error("refill requested after a hit");

  // R2: page number and identifier stay put while the request waits
  p_ask_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mt_req_valid && !mt_req_ready) |=> ($stable(mt_req_vpn) && $stable(mt_req_asid)))
    else $error("refill request changed while waiting");

  // R3: an installed mapping serves the held lookup on the next cycle
  p_fill_then_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (!req_valid || flush || rsp_valid))
    else $error("lookup did not hit after fill");
endmodule

// File: tb/utlb_dside_tb_top.sv
module utlb_dside_tb_top;
  localparam int CLK_P   = 10;
  localparam int VADDR_W = 32;
  localparam int PAGE_W  = 12;
  localparam int ASID_W  = 8;
  localparam int PFN_W   = 24;
  localparam int ATTR_W  = 3;
  localparam int VPN_W   = VADDR_W - PAGE_W;
  localparam int PADDR_W = PFN_W + PAGE_W;

  typedef struct packed {
    logic [PADDR_W-1:0] pa;
    logic [ATTR_W-1:0]  at;
    logic               miss;
  } exp_t;

  logic               clk = 1'b0;
  logic               rst_n;
  logic [ASID_W-1:0]  cur_asid;
  logic               main_tlb_wr;
  logic               req_valid;
  logic               req_ready;
  logic [VADDR_W-1:0] req_vaddr;
  logic               rsp_valid;
  logic [PADDR_W-1:0] rsp_paddr;
  logic [ATTR_W-1:0]  rsp_attr;
  logic               rsp_miss;
  logic               stall;
  logic               mt_req_valid;
  logic               mt_req_ready;
  logic [VPN_W-1:0]   mt_req_vpn;
  logic [ASID_W-1:0]  mt_req_asid;
  logic               mt_rsp_valid;
  logic               mt_rsp_hit;
  logic [PFN_W-1:0]   mt_rsp_pfn;
  logic [ATTR_W-1:0]  mt_rsp_attr;

  int   n_cmp = 0;
  int   n_bad = 0;
  int   n_mt_req = 0;
  exp_t exp_q[$];

  utlb_dside dut_i (
    .clk(clk), .rst_n(rst_n), .cur_asid(cur_asid), .main_tlb_wr(main_tlb_wr),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_attr(rsp_attr),
    .rsp_miss(rsp_miss), .stall(stall),
    .mt_req_valid(mt_req_valid), .mt_req_ready(mt_req_ready),
    .mt_req_vpn(mt_req_vpn), .mt_req_asid(mt_req_asid),
    .mt_rsp_valid(mt_rsp_valid), .mt_rsp_hit(mt_rsp_hit),
    .mt_rsp_pfn(mt_rsp_pfn), .mt_rsp_attr(mt_rsp_attr)
  );

  initial forever #(CLK_P/2) clk = ~clk;

  function automatic logic [PFN_W-1:0] map_pfn(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a);
    return {4'hA, v} ^ {a, 16'h0000};
  endfunction

  function automatic logic [ATTR_W-1:0] map_attr(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a);
    return v[2:0] ^ a[2:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Main-TLB model: accepts two cycles late, answers two cycles after acceptance
  initial begin : main_tlb_model
    logic [VPN_W-1:0]  cap_vpn;
    logic [ASID_W-1:0] cap_asid;
    mt_req_ready = 1'b0;
    mt_rsp_valid = 1'b0;
    mt_rsp_hit   = 1'b0;
    mt_rsp_pfn   = '0;
    mt_rsp_attr  = '0;
    forever begin
      @(negedge clk);
      mt_rsp_valid = 1'b0;
      #(CLK_P/4);
      if (mt_req_valid) begin
        cap_vpn  = mt_req_vpn;
        cap_asid = mt_req_asid;
        @(negedge clk);
        @(negedge clk);
        mt_req_ready = 1'b1;
        @(negedge clk);
        mt_req_ready = 1'b0;
        n_mt_req++;
        @(negedge clk);
        @(negedge clk);
        mt_rsp_valid = 1'b1;
        mt_rsp_hit   = (cap_vpn[19:16] != 4'hF);
        mt_rsp_pfn   = map_pfn(cap_vpn, cap_asid);
        mt_rsp_attr  = map_attr(cap_vpn, cap_asid);
      end
    end
  end

  // Monitor: pops the scoreboard on every delivered result
  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      if (rst_n && req_valid && req_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1", "unexpected result", 1, 0);
        end else begin
          e = exp_q.pop_front();
          chk(rsp_valid == 1'b1, "R1", "rsp_valid", rsp_valid, 1);
          chk(rsp_paddr == e.pa, e.miss ? "R6" : "R3", "rsp_paddr", rsp_paddr, e.pa);
          chk(rsp_attr == e.at, e.miss ? "R6" : "R1", "rsp_attr", rsp_attr, e.at);
          chk(rsp_miss == e.miss, "R6", "rsp_miss", rsp_miss, e.miss);
        end
      end
    end
  end

  // Driver: pushes the expected result, presents the lookup, checks stall and refill count
  task automatic lookup(input logic [VPN_W-1:0] vpn, input logic [PAGE_W-1:0] off,
                        input int exp_req, input string tag, input int flush_at = -1);
    exp_t e;
    int   base;
    int   cnt;
    bit   done;
    e.miss = (vpn[19:16] == 4'hF);
    e.pa   = e.miss ? '0 : {map_pfn(vpn, cur_asid), off};
    e.at   = e.miss ? '0 : map_attr(vpn, cur_asid);
    exp_q.push_back(e);
    base = n_mt_req;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = {vpn, off};
    cnt  = 0;
    done = 1'b0;
    while (!done && cnt < 200) begin
      #(CLK_P/4);
      if (cnt == 0)
        chk(stall == (exp_req > 0), exp_req > 0 ? "R2" : "R1", "stall at lookup", stall, exp_req > 0);
      if (cnt > 0 && !req_ready && exp_req > 0)
        chk(stall == 1'b1, "R2", "stall while refilling", stall, 1);
      done = req_ready;
      @(negedge clk);
      cnt++;
      main_tlb_wr = (cnt == flush_at);
    end
    req_valid   = 1'b0;
    main_tlb_wr = 1'b0;
    chk(done, tag, "lookup completed", done, 1);
    chk((n_mt_req - base) == exp_req, tag, "refill requests", n_mt_req - base, exp_req);
  endtask

  localparam logic [VPN_W-1:0] PG_A = 20'h00010;
  localparam logic [VPN_W-1:0] PG_B = 20'h00021;
  localparam logic [VPN_W-1:0] PG_C = 20'h00032;
  localparam logic [VPN_W-1:0] PG_D = 20'h00043;
  localparam logic [VPN_W-1:0] PG_E = 20'h00054;
  localparam logic [VPN_W-1:0] PG_X = 20'hF0007;

  initial begin : stimulus
    rst_n       = 1'b0;
    cur_asid    = 8'h05;
    main_tlb_wr = 1'b0;
    req_valid   = 1'b0;
    req_vaddr   = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #(CLK_P/4);
    chk(stall == 1'b0, "R10", "stall after reset", stall, 0);
    chk(mt_req_valid == 1'b0, "R10", "mt_req_valid after reset", mt_req_valid, 0);
    chk(rsp_valid == 1'b0, "R10", "rsp_valid after reset", rsp_valid, 0);

    // R10: empty after reset, so the first lookups miss; R4 fill order 0,2,1,3
    lookup(PG_A, 12'h123, 1, "R10");
    lookup(PG_B, 12'h000, 1, "R2");
    lookup(PG_C, 12'hFFF, 1, "R2");
    lookup(PG_D, 12'h456, 1, "R2");
    // R4: four fills occupied four distinct slots, all still resident
    lookup(PG_A, 12'h789, 0, "R4");
    lookup(PG_B, 12'h00A, 0, "R4");
    lookup(PG_C, 12'h00B, 0, "R4");
    lookup(PG_D, 12'h00C, 0, "R4");
    // R5: touching A makes the pair {B,D} older, with B the older inside it
    lookup(PG_A, 12'h001, 0, "R1");
    lookup(PG_E, 12'h002, 1, "R5");
    lookup(PG_A, 12'h003, 0, "R5");
    lookup(PG_C, 12'h004, 0, "R5");
    lookup(PG_D, 12'h005, 0, "R5");
    lookup(PG_E, 12'h006, 0, "R3");
    lookup(PG_B, 12'h007, 1, "R5");
    // R4: the B fill landed on A's slot (older pair, older slot)
    lookup(PG_A, 12'h008, 1, "R4");
    // R6: unmapped page, nothing cached, repeat asks again
    lookup(PG_X, 12'h010, 1, "R6");
    lookup(PG_X, 12'h011, 1, "R6");
    // R7: identifier change empties the table
    @(negedge clk);
    cur_asid = 8'h3C;
    lookup(PG_C, 12'h020, 1, "R7");
    lookup(PG_C, 12'h021, 0, "R3");
    @(negedge clk);
    cur_asid = 8'h05;
    lookup(PG_C, 12'h022, 1, "R7");
    // R8: main-TLB write empties the table
    @(negedge clk);
    main_tlb_wr = 1'b1;
    @(negedge clk);
    main_tlb_wr = 1'b0;
    lookup(PG_C, 12'h030, 1, "R8");
    // R9: invalidation while the refill request waits forces a second fetch
    lookup(PG_D, 12'h040, 2, "R9", 2);
    lookup(PG_D, 12'h041, 0, "R9");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R1", "results left undelivered", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : watchdog
    #(CLK_P * 100000);
    n_cmp++;
    n_bad++;
    $display("FAIL R2 watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule